// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog timer. It counts ticks of a slow, free-running oscillator. Each tick arrives as a single-cycle enable on `tick_en`, already in step with the system clock. Software must pulse `restart` before the programmed timeout elapses. If it does not, the watchdog responds in one of three ways:

- raising an interrupt;
- issuing a one-cycle reset request;
- raising an interrupt first and then, on the following timeout, a reset.

The timeout is `2^(BASE_LOG2 + code)` ticks, where `code` is a 4-bit period selector and codes above 9 act as 9. With the default `BASE_LOG2 = 11` the periods run from 2K to 1024K ticks, each step doubling the last. Code 5 gives 64K ticks, about half a second at 128 kHz.

Clearing the reset enable or changing the period selector is guarded by a two-write unlock. The first write sets both the change bit and the reset-enable bit. That opens a window of `WIN` (4) system cycles. A write with the change bit at 0 inside that window applies the new reset enable and period together.

An always-on fuse input forces reset mode. While it is asserted, the reset enable reads 1 and the interrupt enable reads 0. A sticky reset flag records each watchdog reset. While the flag is set, the reset enable cannot be cleared.

The control register bit layout (`cfg_wdata` / `cfg_rdata`) is:

| Bit | Field |
|---|---|
| [3:0] | period code |
| [4] | reset enable |
| [5] | change bit (reads 1 while the window is open) |
| [6] | interrupt enable |
| [7] | interrupt flag (write 1 to clear) |

The unlock state machine has two states:

- `ULK_IDLE` → `ULK_OPEN` on an arming write.
- `ULK_OPEN` → `ULK_IDLE` on a committing write, or after the fourth open cycle.
- `ULK_OPEN` → `ULK_OPEN` with the window restarted on a repeated arming write.

The response mode is derived from the effective enables: `MODE_OFF`, `MODE_IRQ`, `MODE_RST`, `MODE_BOTH`. In `MODE_BOTH` an expiry drops the interrupt enable, which moves the block to `MODE_RST`.

Top module: `wdog_guard`

## Requirements
- R1: With the watchdog active, the timeout fires on the tick that brings the count to `2^(BASE_LOG2+code)`. Codes 10 to 15 time out like code 9. Cycles without `tick_en` do not advance the count.
- R2: A `restart` pulse clears the count, and no timeout fires in that cycle, even if a tick arrives with it.
- R3: In interrupt-only mode a timeout sets bit 7 and drives `irq` high. Bit 6 stays 1 and `wd_rst` stays low.
- R4: In reset mode a timeout drives `wd_rst` high for exactly one clock cycle and sets `rst_flag`. `irq` is not raised.
- R5: With both enables set, the first timeout sets the interrupt flag and clears bit 6 without a reset. The next timeout pulses `wd_rst`.
- R6: While `fuse_on` is 1, bit 4 reads 1 and bit 6 reads 0 whatever is written, and a timeout produces a reset.
- R7: A write with bits 5 and 4 both 1 opens the change window. Bit 5 then reads 1 for exactly 4 cycles. A write with bit 5 at 0 during any of those 4 cycles loads bits [3:0] and bit 4 together and closes the window.
- R8: A write made with the window closed, including the cycle after it has expired, leaves bits [3:0] unchanged and cannot clear bit 4.
- R9: `rst_flag` stays 1 until `flag_wr` is pulsed with `flag_wdata` at 0. Writing 1 has no effect. While the flag is 1, even a committing write cannot clear bit 4.
- R10: Writing 1 to bit 7 clears the interrupt flag and `irq`. Writing 0 there leaves them unchanged.
- R11: With both effective enables at 0, ticks produce neither `irq` nor `wd_rst`.
- R12: If the period code shrinks below the current count, the next tick fires the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per slow-oscillator tick |
| restart | input | 1 | Watchdog restart strobe |
| fuse_on | input | 1 | Always-on fuse; forces reset mode |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| flag_wr | input | 1 | Reset-flag register write strobe |
| flag_wdata | input | 1 | Reset-flag write value (0 clears) |
| irq | output | 1 | Watchdog interrupt (level, follows flag) |
| wd_rst | output | 1 | One-cycle system reset request |
| rst_flag | output | 1 | Sticky watchdog-reset flag |

## Verification
The assertions check, on every cycle:
- that a reset request never lasts past one cycle;
- that the fuse locks the enable readback;
- that the period code only changes one cycle after the window was open;
- that the reset flag and the reset enable stay set while the flag is set;
- that a combined-mode expiry drops the interrupt enable;
- that the change window never stays open longer than four cycles.

Exact timeout lengths per code need the bench's scenarios. So do the reserved-code clamp, the accept-on-fourth/reject-on-fifth window boundary, restart timing and the shorten-below-count case. The bench compares these against its cycle-level reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int PSEL_W   = 4;
    localparam int F_RSTEN  = 4;
    localparam int F_CHG    = 5;
    localparam int F_IRQEN  = 6;
    localparam int F_IFLAG  = 7;
    localparam int CTRL_W   = 8;
    localparam int MAX_CODE = 9;

    typedef enum logic {
        ULK_IDLE,
        ULK_OPEN
    } ulk_state_t;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_IRQ,
        MODE_RST,
        MODE_BOTH
    } wd_mode_t;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic chg_bit,
    input  logic rsten_bit,
    output logic win_open,
    output logic commit
);
    localparam int LW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int RW = LW + 1;

    ulk_state_t    state_q, state_d;
    logic [LW-1:0] left_q, left_d;
    logic          arm;

    assign arm = wr && chg_bit && rsten_bit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ULK_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ULK_IDLE: begin
                if (arm) begin
                    state_d = ULK_OPEN;
                    left_d  = LW'(WIN - 1);
                end
            end
            ULK_OPEN: begin
                if (wr && !chg_bit) begin
                    state_d = ULK_IDLE;
                end else if (arm) begin
                    left_d = LW'(WIN - 1);
                end else if (left_q == '0) begin
                    state_d = ULK_IDLE;
                end else begin
                    left_d = left_q - LW'(1);
                end
            end
            default: state_d = ULK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        win_open = (state_q == ULK_OPEN);
        commit   = win_open && wr && !chg_bit;
    end

    // open-run length, for the window-length check
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (arm)      run_q <= RW'(1);
        else if (win_open) run_q <= run_q + RW'(1);
        else               run_q <= '0;
    end

    assert_window_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (run_q <= RW'(WIN)));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int CW        = BASE_LOG2 + MAX_CODE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              expire
);
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     lim_m1;
    logic [PSEL_W-1:0] code;

    always_comb begin
        code   = (psel > PSEL_W'(MAX_CODE)) ? PSEL_W'(MAX_CODE) : psel;
        lim_m1 = (CW'(1) << (BASE_LOG2 + int'(code))) - CW'(1);
        expire = active && tick && !restart && (cnt_q >= lim_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!active || restart) cnt_q <= '0;
        else if (tick)              cnt_q <= expire ? '0 : cnt_q + CW'(1);
    end

    assert_restart_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    assert_tick_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse,
    input  logic              wr,
    input  logic              wd_iflag,
    input  logic              wd_irqen,
    input  logic              wd_rsten,
    input  logic [PSEL_W-1:0] wd_psel,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              win_open,
    input  logic              commit,
    input  logic              expire,
    output logic [PSEL_W-1:0] psel,
    output logic              active,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              irq,
    output logic              wd_rst,
    output logic              rst_flag
);
    logic [PSEL_W-1:0] psel_q;
    logic rsten_q, irqen_q, iflag_q, rflag_q, wdrst_q;
    logic eff_rst, eff_irq;
    logic do_irq, do_rst, drop_irqen;
    wd_mode_t mode;

    always_comb begin
        eff_rst = fuse || rsten_q;
        eff_irq = !fuse && irqen_q;
        unique case ({eff_rst, eff_irq})
            2'b00:   mode = MODE_OFF;
            2'b01:   mode = MODE_IRQ;
            2'b10:   mode = MODE_RST;
            default: mode = MODE_BOTH;
        endcase
    end

    // response per mode
    always_comb begin
        do_irq     = 1'b0;
        do_rst     = 1'b0;
        drop_irqen = 1'b0;
        unique case (mode)
            MODE_OFF:  ;
            MODE_IRQ:  do_irq = expire;
            MODE_RST:  do_rst = expire;
            MODE_BOTH: begin
                do_irq     = expire;
                drop_irqen = expire;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel_q  <= '0;
            rsten_q <= 1'b0;
            irqen_q <= 1'b0;
            iflag_q <= 1'b0;
            rflag_q <= 1'b0;
            wdrst_q <= 1'b0;
        end else begin
            if (commit) psel_q <= wd_psel;

            if (commit)              rsten_q <= wd_rsten || (rsten_q && rflag_q);
            else if (wr && wd_rsten) rsten_q <= 1'b1;

            if (drop_irqen) irqen_q <= 1'b0;
            else if (wr)    irqen_q <= wd_irqen;

            if (do_irq)              iflag_q <= 1'b1;
            else if (wr && wd_iflag) iflag_q <= 1'b0;

            wdrst_q <= do_rst;

            if (do_rst)                     rflag_q <= 1'b1;
            else if (flag_wr && !flag_wdata) rflag_q <= 1'b0;
        end
    end

    always_comb begin
        psel      = psel_q;
        active    = (mode != MODE_OFF);
        cfg_rdata = {iflag_q, eff_irq, win_open, eff_rst, psel_q};
        irq       = iflag_q;
        wd_rst    = wdrst_q;
        rst_flag  = rflag_q;
    end

    assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> !wd_rst);
    assert_fuse_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fuse |-> (cfg_rdata[F_RSTEN] && !cfg_rdata[F_IRQEN]));
    assert_combined_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BOTH && expire) |=> (iflag_q && !irqen_q && !wd_rst));
    assert_psel_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(psel_q) |-> $past(win_open));
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag_q && !(flag_wr && !flag_wdata)) |=> rflag_q);
    assert_rsten_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag_q && rsten_q) |=> rsten_q);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int WIN       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              restart,
    input  logic              fuse_on,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic              irq,
    output logic              wd_rst,
    output logic              rst_flag
);
    localparam int CW = BASE_LOG2 + MAX_CODE + 1;

    logic              win_open, commit, expire, active;
    logic [PSEL_W-1:0] psel;

    wdog_unlock #(.WIN(WIN)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .chg_bit   (cfg_wdata[F_CHG]),
        .rsten_bit (cfg_wdata[F_RSTEN]),
        .win_open  (win_open),
        .commit    (commit)
    );

    wdog_count #(.BASE_LOG2(BASE_LOG2), .CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .tick    (tick_en),
        .restart (restart),
        .psel    (psel),
        .expire  (expire)
    );

    wdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fuse       (fuse_on),
        .wr         (cfg_wr),
        .wd_iflag   (cfg_wdata[F_IFLAG]),
        .wd_irqen   (cfg_wdata[F_IRQEN]),
        .wd_rsten   (cfg_wdata[F_RSTEN]),
        .wd_psel    (cfg_wdata[PSEL_W-1:0]),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .win_open   (win_open),
        .commit     (commit),
        .expire     (expire),
        .psel       (psel),
        .active     (active),
        .cfg_rdata  (cfg_rdata),
        .irq        (irq),
        .wd_rst     (wd_rst),
        .rst_flag   (rst_flag)
    );
endmodule

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, restart = 1'b0, fuse_on = 1'b0;
    logic       cfg_wr = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b1;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       irq, wd_rst, rst_flag;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wdog_guard #(.BASE_LOG2(BASE), .WIN(4)) u_wdog_guard (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
        .fuse_on(fuse_on), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .irq(irq), .wd_rst(wd_rst), .rst_flag(rst_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_cnt, m_left, m_psel;
    bit m_open, m_rsten, m_irqen, m_iflag, m_rflag, m_wdrst;
    int code, lim, n_cnt;
    bit er, ei, act, exp_ev, n_wdrst, n_iflag, n_irqen, n_rflag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_left = 0; m_psel = 0; m_open = 0;
            m_rsten = 0; m_irqen = 0; m_iflag = 0; m_rflag = 0; m_wdrst = 0;
        end else begin
            er     = fuse_on || m_rsten;
            ei     = !fuse_on && m_irqen;
            act    = er || ei;
            code   = (m_psel > 9) ? 9 : m_psel;
            lim    = 1 << (BASE + code);
            exp_ev = act && tick_en && !restart && (m_cnt >= lim - 1);
            if (!act || restart) n_cnt = 0;
            else if (tick_en)    n_cnt = exp_ev ? 0 : m_cnt + 1;
            else                 n_cnt = m_cnt;
            n_wdrst = exp_ev && er && !ei;
            n_iflag = (exp_ev && ei) ? 1'b1 : ((cfg_wr && cfg_wdata[7]) ? 1'b0 : m_iflag);
            n_irqen = (exp_ev && ei && er) ? 1'b0 : (cfg_wr ? cfg_wdata[6] : m_irqen);
            n_rflag = n_wdrst ? 1'b1 : ((flag_wr && !flag_wdata) ? 1'b0 : m_rflag);
            if (cfg_wr && m_open && !cfg_wdata[5]) begin
                m_psel  = int'(cfg_wdata[3:0]);
                m_rsten = cfg_wdata[4] || (m_rsten && m_rflag);
                m_open  = 0;
            end else if (cfg_wr && cfg_wdata[5] && cfg_wdata[4]) begin
                m_rsten = 1; m_open = 1; m_left = 3;
            end else begin
                if (cfg_wr && cfg_wdata[4]) m_rsten = 1;
                if (m_open) begin
                    if (m_left == 0) m_open = 0;
                    else m_left--;
                end
            end
            m_cnt = n_cnt; m_wdrst = n_wdrst; m_iflag = n_iflag;
            m_irqen = n_irqen; m_rflag = n_rflag;
        end
        #5;
        if (rst_n) begin
            chk("R3 irq per-cycle", int'(irq), int'(m_iflag));
            chk("R4 wd_rst per-cycle", int'(wd_rst), int'(m_wdrst));
            chk("R9 rst_flag per-cycle", int'(rst_flag), int'(m_rflag));
            chk("R7 cfg_rdata per-cycle", int'(cfg_rdata),
                int'({m_iflag, !fuse_on && m_irqen, m_open, fuse_on || m_rsten, 4'(m_psel)}));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_cfg(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic unlock_set(input logic [7:0] d);
        wr_cfg({1'b0, d[6], 2'b11, 4'h0});
        wr_cfg(d & 8'hDF);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic kick();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic pulse_flag(input logic v);
        flag_wr = 1'b1; flag_wdata = v;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b1;
    endtask

    task automatic measure(output int n);
        kick();
        n = 0;
        tick_en = 1'b1;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (irq) break;
        end
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        int open_cycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset state R11", int'({cfg_rdata, irq, wd_rst, rst_flag}), 0);

        // R11: nothing enabled
        ticks(40);
        chk("R11 no irq when off", int'(irq), 0);
        chk("R11 no rst flag when off", int'(rst_flag), 0);

        // R3 / R1: interrupt mode, code 0 -> 4 ticks
        wr_cfg(8'h40);
        ticks(3);
        chk("R1 no expiry before limit", int'(irq), 0);
        ticks(1);
        chk("R3 irq on timeout", int'(irq), 1);
        chk("R3 irq_en kept", int'(cfg_rdata[6]), 1);
        chk("R3 no reset in irq mode", int'(rst_flag), 0);

        // R10: flag clear
        wr_cfg(8'h40);
        chk("R10 write 0 keeps flag", int'(irq), 1);
        wr_cfg(8'hC0);
        chk("R10 write 1 clears flag", int'(irq), 0);

        // R2: restart
        ticks(3);
        kick();
        ticks(3);
        chk("R2 restart postpones timeout", int'(irq), 0);
        ticks(1);
        chk("R2 timeout after restart", int'(irq), 1);
        wr_cfg(8'hC0);

        // R7 / R8: window behaviour
        wr_cfg(8'h70);
        open_cycles = 0;
        while (cfg_rdata[5] && open_cycles < 10) begin
            open_cycles++;
            @(negedge clk);
        end
        chk("R7 window open 4 cycles", open_cycles, 4);
        wr_cfg(8'h41);
        chk("R8 late write rejected", int'(cfg_rdata[4:0]), 5'h10);
        unlock_set(8'h41);
        chk("R7 committed write", int'(cfg_rdata), 8'h41);
        wr_cfg(8'h70);
        repeat (4) @(negedge clk);
        wr_cfg(8'h43);
        chk("R8 write on fifth cycle rejected", int'(cfg_rdata), 8'h51);
        wr_cfg(8'h70);
        repeat (3) @(negedge clk);
        wr_cfg(8'h42);
        chk("R7 write on fourth cycle accepted", int'(cfg_rdata), 8'h42);
        unlock_set(8'h41);

        // R1: timeout lengths
        measure(n);
        chk("R1 code 1 timeout ticks", n, 8);
        wr_cfg(8'hC0);
        unlock_set(8'h4F);
        chk("R1 reserved code readback", int'(cfg_rdata), 8'h4F);
        measure(n);
        chk("R1 reserved code clamps to 9", n, 2048);
        wr_cfg(8'hC0);

        // R12: shrink below current count
        unlock_set(8'h43);
        kick();
        ticks(20);
        chk("R12 no expiry at code 3", int'(irq), 0);
        unlock_set(8'h40);
        ticks(1);
        chk("R12 shorten fires on next tick", int'(irq), 1);
        wr_cfg(8'hC0);

        // R4: reset mode
        unlock_set(8'h10);
        kick();
        ticks(3);
        chk("R4 no reset before limit", int'(wd_rst), 0);
        ticks(1);
        chk("R4 reset pulse high", int'(wd_rst), 1);
        @(negedge clk);
        chk("R4 reset pulse one cycle", int'(wd_rst), 0);
        chk("R4 reset flag set", int'(rst_flag), 1);
        chk("R4 no irq in reset mode", int'(irq), 0);

        // R9: sticky flag and rst_en lock
        unlock_set(8'h00);
        chk("R9 rst_en held by flag", int'(cfg_rdata[4]), 1);
        pulse_flag(1'b1);
        chk("R9 flag write 1 ignored", int'(rst_flag), 1);
        pulse_flag(1'b0);
        chk("R9 flag write 0 clears", int'(rst_flag), 0);
        unlock_set(8'h00);
        chk("R9 rst_en clears after flag", int'(cfg_rdata), 8'h00);

        // R5: combined mode
        wr_cfg(8'h50);
        kick();
        ticks(4);
        chk("R5 first timeout irq", int'(irq), 1);
        chk("R5 irq_en dropped", int'(cfg_rdata[6]), 0);
        chk("R5 no reset on first timeout", int'(rst_flag), 0);
        ticks(3);
        chk("R5 no reset early", int'(wd_rst), 0);
        ticks(1);
        chk("R5 second timeout resets", int'(wd_rst), 1);
        wr_cfg(8'h90);
        pulse_flag(1'b0);
        unlock_set(8'h00);

        // R6: fuse
        fuse_on = 1'b1;
        @(negedge clk);
        chk("R6 fuse forces rst_en", int'(cfg_rdata[4]), 1);
        wr_cfg(8'h40);
        chk("R6 fuse masks irq_en write", int'(cfg_rdata[6]), 0);
        kick();
        ticks(3);
        ticks(1);
        chk("R6 fuse timeout resets", int'(wd_rst), 1);
        chk("R6 fuse timeout no irq", int'(irq), 0);
        fuse_on = 1'b0;
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule